// File: doc/BRIEF.md
# Boot Mode Capture and External Interrupt Pins

This block serves a group of dual-use processor pins. While the chip reset is held, the pins are read as a boot-mode code. The code sampled at the last clock edge of reset stays in a mode register for the rest of the run. Once reset has ended, the same pins act as active-low external interrupt requests.

Each request line passes through a synchronizer. A per-line control bit selects the trigger. In level mode the line is pending while the synchronized pin is low. In falling-edge mode a falling edge latches a pending bit, and that bit holds until a clear pulse removes it. A per-line enable gates the pending flags that go to the interrupt controller.

The block also raises wake requests toward the core's standby logic, and these ignore the enables. Lines marked by a parameter can end the deeper STOP state as well as WAIT. The other lines can end WAIT only. Edge detection stays off during reset and until the synchronizer holds only post-reset samples, so a pin that moves as reset ends does not raise an interrupt.

Top module: `boot_irq_pins`

## Requirements
- R1: While `rst_n` is low, every rising clock edge loads `mode_pins_n` into `boot_mode`. After reset is released, `boot_mode` holds the value taken at the last edge at which `rst_n` was low.
- R2: While `rst_n` stays high, `boot_mode` does not change, whatever the pins do.
- R3: A line in level mode (`trig_fall[i]`=0) has a raw request equal to the inverted pin value from two rising edges earlier. A pin change made before edge k is seen after edge k+1. The raw request is 0 while the line is not yet armed.
- R4: A line in falling-edge mode (`trig_fall[i]`=1) sets its pending bit at edge k+2 when the pin falls before edge k. The bit stays set after the pin rises again.
- R5: A high `pend_clr[i]` at an edge clears line i's latched bit. A new falling edge that would set the bit at that same edge wins over the clear.
- R6: `irq_pending[i]` is the raw request of line i ANDed with `irq_en[i]`. A disabled line shows 0 there.
- R7: `wake_stop` is high when `in_stop` is high and some line selected by `STOP_WAKE_LINES` has a raw request. With the default, only line 0 is selected.
- R8: `wake_wait` is high when `in_wait` is high and any line has a raw request, whether or not that line is enabled.
- R9: No pending bit is set by a pin fall made before the release edge. Lines arm two edges after release. A fall made in the first cycle after release is detected.
- R10: While `rst_n` is low, `irq_pending`, `wake_stop` and `wake_wait` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; boot-mode sampling while low |
| mode_pins_n | input | LINES | Boot-mode code during reset, active-low interrupt requests afterwards |
| trig_fall | input | LINES | Per line: 1 = falling-edge latched, 0 = level |
| irq_en | input | LINES | Per-line enable for `irq_pending` |
| pend_clr | input | LINES | Per-line clear of the latched edge bit |
| in_stop | input | 1 | Core is in STOP standby |
| in_wait | input | 1 | Core is in WAIT standby |
| boot_mode | output | LINES | Captured boot-mode code |
| irq_pending | output | LINES | Enabled pending requests to the interrupt controller |
| wake_stop | output | 1 | Request to leave STOP |
| wake_wait | output | 1 | Request to leave WAIT |

## Verification
The bench builds the block with its defaults: four lines, a two-flop synchronizer, and only line 0 able to end STOP. With these values all sixteen boot codes can appear, and lines that can and cannot leave STOP sit side by side, so the masked-line and WAIT-only wake paths are both exercised. A behavioural model tracks pin history, arming and latched bits and is compared with every output after every edge. It runs under directed sequences for reset release, set-wins-over-clear and disabled lines, and then under a long stretch of pseudo-random pins, triggers, clears and standby states with a second reset in the middle.

// File: rtl/boot_irq_pkg.sv
package boot_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;

  localparam int SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/boot_mode_latch.sv
module boot_mode_latch #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_n,
  output logic [WIDTH-1:0] mode
);
  logic [WIDTH-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= pins_n;
  end

  assign mode = mode_q;

  // R1: the first cycle out of reset shows the code sampled at the last reset edge
  assert_mode_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> mode_q == $past(pins_n));

  // R2: no change while reset stays released
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic sync_n,
  output logic fall,
  output logic armed
);
  logic [STAGES-1:0] shift_q;
  logic              prev_q;
  logic [STAGES-1:0] arm_q;

  always_ff @(posedge clk) begin
    shift_q <= {shift_q[STAGES-2:0], pin_n};
    prev_q  <= shift_q[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= {arm_q[STAGES-2:0], 1'b1};
  end

  assign sync_n = shift_q[STAGES-1];
  assign armed  = arm_q[STAGES-1];
  assign fall   = armed & prev_q & ~shift_q[STAGES-1];

  // R9: arming is reached only after the synchronizer has been refilled
  assert_arm_late_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !armed);
endmodule

// File: rtl/irq_line_pend.sv
module irq_line_pend
  import boot_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic fall,
  input  logic armed,
  input  logic trig_sel,
  input  logic clr,
  input  logic en,
  output logic raw,
  output logic pend
);
  trig_e trig;
  logic  latched_q;
  logic  set_now;

  assign trig    = trig_e'(trig_sel);
  assign set_now = fall & (trig == TRIG_FALL);

  always_ff @(posedge clk) begin
    if (!rst_n)       latched_q <= 1'b0;
    else if (set_now) latched_q <= 1'b1;
    else if (clr)     latched_q <= 1'b0;
  end

  always_comb begin
    if (trig == TRIG_FALL) raw = latched_q;
    else                   raw = armed & ~sync_n;
  end

  assign pend = raw & en;

  // R4: a latched bit survives any cycle without a clear
  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    latched_q && !clr |=> latched_q);

  // R5: a clear without a simultaneous new edge empties the bit
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set_now |=> !latched_q);

  // R9: nothing is latched while the line is still unarmed
  assert_no_early_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !latched_q);
endmodule

// File: rtl/boot_irq_pins.sv
module boot_irq_pins
  import boot_irq_pkg::*;
#(
  parameter int               LINES           = 4,
  parameter int               SYNC_STAGES     = SYNC_STAGES_DEF,
  parameter logic [LINES-1:0] STOP_WAKE_LINES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] mode_pins_n,
  input  logic [LINES-1:0] trig_fall,
  input  logic [LINES-1:0] irq_en,
  input  logic [LINES-1:0] pend_clr,
  input  logic             in_stop,
  input  logic             in_wait,
  output logic [LINES-1:0] boot_mode,
  output logic [LINES-1:0] irq_pending,
  output logic             wake_stop,
  output logic             wake_wait
);
  logic [LINES-1:0] sync_n;
  logic [LINES-1:0] fall;
  logic [LINES-1:0] armed;
  logic [LINES-1:0] raw;

  boot_mode_latch #(.WIDTH(LINES)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_n (mode_pins_n),
    .mode   (boot_mode)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (mode_pins_n[i]),
      .sync_n (sync_n[i]),
      .fall   (fall[i]),
      .armed  (armed[i])
    );

    irq_line_pend u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_n   (sync_n[i]),
      .fall     (fall[i]),
      .armed    (armed[i]),
      .trig_sel (trig_fall[i]),
      .clr      (pend_clr[i]),
      .en       (irq_en[i]),
      .raw      (raw[i]),
      .pend     (irq_pending[i])
    );
  end

  assign wake_stop = in_stop & |(raw & STOP_WAKE_LINES);
  assign wake_wait = in_wait & |raw;

  // R10: nothing leaves the block during the first cycle after a reset edge
  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_pending == '0) && !wake_stop && !wake_wait);
endmodule

// File: tb/tb_boot_irq_pins.sv
module tb_boot_irq_pins;
  localparam int L = 4;
  localparam logic [L-1:0] STOPMASK = 4'b0001;

  logic clk = 0;
  logic rst_n;
  logic [L-1:0] pins, trig, en, clr;
  logic in_stop, in_wait;
  logic [L-1:0] boot_mode, irq_pending;
  logic wake_stop, wake_wait;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  boot_irq_pins dut (
    .clk(clk), .rst_n(rst_n), .mode_pins_n(pins), .trig_fall(trig),
    .irq_en(en), .pend_clr(clr), .in_stop(in_stop), .in_wait(in_wait),
    .boot_mode(boot_mode), .irq_pending(irq_pending),
    .wake_stop(wake_stop), .wake_wait(wake_wait)
  );

  // reference model state
  logic [L-1:0] m_mode, m_s1, m_s2, m_pv, m_lat;
  logic m_a0, m_arm;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic step();
    logic [L-1:0] p, t, c, e, raw, set;
    logic r, st, wt;
    p = pins; t = trig; c = clr; e = en; r = rst_n; st = in_stop; wt = in_wait;
    @(posedge clk);
    if (!r) begin
      m_mode = p; m_lat = '0; m_a0 = 0; m_arm = 0;
    end else begin
      set = {L{m_arm}} & t & m_pv & ~m_s2;
      m_lat = set | (m_lat & ~c);
      m_arm = m_a0;
      m_a0  = 1'b1;
    end
    m_pv = m_s2; m_s2 = m_s1; m_s1 = p;
    #2;
    for (int i = 0; i < L; i++)
      raw[i] = t[i] ? m_lat[i] : (m_arm & ~m_s2[i]);
    chk(boot_mode == m_mode, r ? "R2" : "R1", boot_mode, m_mode);
    for (int i = 0; i < L; i++)
      chk(irq_pending[i] == (raw[i] & e[i]), !e[i] ? "R6" : (t[i] ? "R4" : "R3"),
          irq_pending[i], raw[i] & e[i]);
    chk(wake_stop == (st & |(raw & STOPMASK)), "R7", wake_stop, st & |(raw & STOPMASK));
    chk(wake_wait == (wt & |raw), "R8", wake_wait, wt & |raw);
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; pins = '1; trig = 4'b1101; en = '1; clr = '0; in_stop = 0; in_wait = 1;
    m_s1 = '1; m_s2 = '1; m_pv = '1; m_lat = '0; m_a0 = 0; m_arm = 0; m_mode = '1;
    repeat (3) step();
    chk(irq_pending == 0 && !wake_stop && !wake_wait, "R10", irq_pending, 0);
    // line 0 and line 3 fall right at the end of reset
    pins = 4'b0110;
    step();
    rst_n = 1;
    repeat (4) step();
    chk(boot_mode == 4'b0110, "R1", boot_mode, 4'b0110);
    chk(irq_pending[0] == 0 && irq_pending[3] == 0, "R9", irq_pending, 0);
    pins = 4'b1111;
    repeat (3) step();
    chk(boot_mode == 4'b0110, "R2", boot_mode, 4'b0110);
    in_wait = 0;
    // falling edge on line 0
    pins[0] = 0;
    repeat (2) step();
    chk(irq_pending[0] == 0, "R4", irq_pending[0], 0);
    step();
    chk(irq_pending[0] == 1, "R4", irq_pending[0], 1);
    pins[0] = 1;
    repeat (3) step();
    chk(irq_pending[0] == 1, "R4", irq_pending[0], 1);
    in_stop = 1; step();
    chk(wake_stop == 1, "R7", wake_stop, 1);
    in_stop = 0;
    clr[0] = 1; step(); clr = '0;
    chk(irq_pending[0] == 0, "R5", irq_pending[0], 0);
    // set wins over clear
    pins[0] = 0;
    repeat (2) step();
    clr[0] = 1; step(); clr = '0;
    chk(irq_pending[0] == 1, "R5", irq_pending[0], 1);
    clr[0] = 1; step(); clr = '0;
    pins[0] = 1;
    repeat (3) step();
    // level line 1
    pins[1] = 0;
    step();
    chk(irq_pending[1] == 0, "R3", irq_pending[1], 0);
    step();
    chk(irq_pending[1] == 1, "R3", irq_pending[1], 1);
    in_stop = 1; step();
    chk(wake_stop == 0, "R7", wake_stop, 0);
    in_stop = 0;
    en[1] = 0; step();
    chk(irq_pending == 0, "R6", irq_pending, 0);
    in_wait = 1; step();
    chk(wake_wait == 1, "R8", wake_wait, 1);
    pins[1] = 1;
    repeat (2) step();
    chk(wake_wait == 0, "R8", wake_wait, 0);
    in_wait = 0; en = '1;
    // fall in the first cycle after a fresh release is detected
    rst_n = 0; pins = 4'b1001; repeat (2) step();
    chk(irq_pending == 0, "R10", irq_pending, 0);
    rst_n = 1; step();
    chk(boot_mode == 4'b1001, "R1", boot_mode, 4'b1001);
    pins = 4'b1000;
    repeat (3) step();
    chk(irq_pending[0] == 1, "R9", irq_pending[0], 1);
    // pseudo-random stretch
    for (int k = 0; k < 3000; k++) begin
      pins    = 4'($urandom);
      clr     = 4'($urandom) & 4'($urandom);
      en      = 4'($urandom) | 4'($urandom);
      in_stop = 1'($urandom);
      in_wait = 1'($urandom);
      if (k % 97 == 0) trig = 4'($urandom);
      rst_n   = (k % 700 < 3) ? 1'b0 : 1'b1;
      step();
    end
    done = 1;
    summary();
    $finish;
  end
endmodule